// File: doc/BRIEF.md
# USB Endpoint Halt Status Tracker

This block holds the halted (stalled) state of the endpoints of a USB device function and presents it as one read-only status byte. Endpoints 0 through 4 and endpoint 7 have state. A request decoder, the packet engine and firmware report events to the block as single-cycle pulses: stall conditions (overrun, undefined request), SETUP tokens, the standard requests that touch the halt feature, and firmware clear strobes. Each pulse carries an endpoint or interface number. The block updates its state at the clock edge that samples the pulse.

Endpoint 0 is handled apart from the others. It has two kinds of halt. The first is a protocol stall, which raises the send-stall flag and goes away on the next SETUP. The second is a feature halt, which only a clear-feature request or firmware removes. Endpoint 0 also has a read mask, which hides its halt bit while certain requests are being serviced. The mask stays on until the next SETUP. For the other endpoints, a halt is cleared by a clear-feature request, by firmware, or by a completed set-interface or set-configuration request that covers the endpoint's interface. Those two requests never clear endpoint 0.

Top module: `ep_halt_tracker`

## Requirements
- R1: `halt_status` bit k shows the halt of endpoint k for k = 0..4, bit 7 shows endpoint 7, and bits 5 and 6 always read 0. After reset the byte is 00h and `send_stall` is 0.
- R2: A stall pulse with endpoint number n (n in 0..4 or 7) halts endpoint n. Endpoint numbers 5 and 6 have no effect.
- R3: A stall pulse on endpoint 0 raises `send_stall` and halt bit 0 together. The next SETUP pulse clears `send_stall`, and with it that protocol halt.
- R4: SET_FEATURE(halt) to endpoint n halts it. On endpoint 0 this halt survives any number of SETUP pulses and clears only on CLEAR_FEATURE(halt) to endpoint 0 or on `fw_clr[0]`. `fw_clr[0]` does not clear the protocol halt.
- R5: Bit 0 reads 0 from the cycle after any of these arrives: GET_STATUS, CLEAR_FEATURE or SET_FEATURE to endpoint 0, or a firmware-decoded request. It reads 0 until the cycle after the next SETUP pulse, and the underlying halt state is kept.
- R6: The halt of endpoint n (n not 0) clears on CLEAR_FEATURE(halt) to n, on `fw_clr[n]`, on SET_CONFIGURATION, or on SET_INTERFACE whose number equals the endpoint's field `ep_if_map[n*IF_W +: IF_W]`. SETUP and non-matching SET_INTERFACE leave it set.
- R7: SET_INTERFACE and SET_CONFIGURATION never clear either halt of endpoint 0.
- R8: A bit of `halt_status` reads 0 while its `ep_en` bit is 0. The halt state is kept and shows again once the bit returns to 1.
- R9: When a set event and a clear event hit the same endpoint state in one cycle, the state ends set.
- R10: Every event is sampled at a rising clock edge, and its effect is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_en | input | 8 | Per-endpoint enable in the active interface setting |
| ep_if_map | input | 8*IF_W | Interface number per endpoint, field n for endpoint n |
| stall_evt | input | 1 | Stall condition pulse (overrun / undefined request) |
| stall_ep | input | 3 | Endpoint of the stall condition |
| setup_evt | input | 1 | SETUP token received |
| setfeat_evt | input | 1 | SET_FEATURE(halt) received |
| setfeat_ep | input | 3 | Target endpoint of SET_FEATURE |
| clrfeat_evt | input | 1 | CLEAR_FEATURE(halt) received |
| clrfeat_ep | input | 3 | Target endpoint of CLEAR_FEATURE |
| getstat_evt | input | 1 | GET_STATUS to an endpoint received |
| getstat_ep | input | 3 | Target endpoint of GET_STATUS |
| fwdec_evt | input | 1 | Request handed to firmware for decoding |
| setif_evt | input | 1 | SET_INTERFACE completed |
| setif_num | input | IF_W | Interface addressed by SET_INTERFACE |
| setcfg_evt | input | 1 | SET_CONFIGURATION completed |
| fw_clr | input | 8 | Firmware halt-clear strobes, bit n for endpoint n |
| halt_status | output | 8 | Halt status byte |
| send_stall | output | 1 | Endpoint 0 protocol stall flag |

## Verification
The hardest case to reach is endpoint 0 holding a feature halt while the read mask is up, with a SETUP, a SET_CONFIGURATION or a stall arriving in the same window. Random pulses rarely line these up. Directed steps therefore walk endpoint 0 through a set-feature (masked), SETUP (visible), configuration change (kept), status read (masked) and clear-feature sequence. After that, seeded random traffic with coincident events runs against a reference model to cover the same-cycle collisions.

// File: rtl/ep_halt_tracker.sv
module ep_halt_tracker #(
  parameter int IF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ep_en,
  input  logic [8*IF_W-1:0] ep_if_map,
  input  logic              stall_evt,
  input  logic [2:0]        stall_ep,
  input  logic              setup_evt,
  input  logic              setfeat_evt,
  input  logic [2:0]        setfeat_ep,
  input  logic              clrfeat_evt,
  input  logic [2:0]        clrfeat_ep,
  input  logic              getstat_evt,
  input  logic [2:0]        getstat_ep,
  input  logic              fwdec_evt,
  input  logic              setif_evt,
  input  logic [IF_W-1:0]   setif_num,
  input  logic              setcfg_evt,
  input  logic [7:0]        fw_clr,
  output logic [7:0]        halt_status,
  output logic              send_stall
);

  localparam logic [7:0] OTHER_EPS = 8'b1001_1110;

  logic [7:0] stall_hit, sf_hit, cf_hit, gs_hit, if_hit;
  logic [7:0] set_v, clr_v, other_q;
  logic       feat0_q, mask0_q, mask0_set;

  assign stall_hit = stall_evt   ? (8'd1 << stall_ep)   : 8'd0;
  assign sf_hit    = setfeat_evt ? (8'd1 << setfeat_ep) : 8'd0;
  assign cf_hit    = clrfeat_evt ? (8'd1 << clrfeat_ep) : 8'd0;
  assign gs_hit    = getstat_evt ? (8'd1 << getstat_ep) : 8'd0;

  for (genvar n = 0; n < 8; n++) begin : g_ifm
    assign if_hit[n] = setif_evt && (ep_if_map[n*IF_W +: IF_W] == setif_num);
  end

  assign set_v = stall_hit | sf_hit;
  assign clr_v = cf_hit | fw_clr | if_hit | {8{setcfg_evt}};

  always_ff @(posedge clk) begin
    if (!rst_n) other_q <= 8'd0;
    else        other_q <= (set_v | (other_q & ~clr_v)) & OTHER_EPS;
  end

  assign mask0_set = gs_hit[0] | cf_hit[0] | sf_hit[0] | fwdec_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_stall <= 1'b0;
      feat0_q    <= 1'b0;
      mask0_q    <= 1'b0;
    end else begin
      if (stall_hit[0])                 send_stall <= 1'b1;
      else if (setup_evt)               send_stall <= 1'b0;
      if (sf_hit[0])                    feat0_q <= 1'b1;
      else if (cf_hit[0] || fw_clr[0])  feat0_q <= 1'b0;
      if (mask0_set)                    mask0_q <= 1'b1;
      else if (setup_evt)               mask0_q <= 1'b0;
    end
  end

  logic ep0_halt;
  assign ep0_halt    = send_stall | feat0_q;
  assign halt_status = {other_q[7:1], ep0_halt & ~mask0_q} & ep_en;

  a_r3_stall_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt && stall_ep == 3'd0 |=> send_stall);

  a_r3_setup_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt && !(stall_evt && stall_ep == 3'd0) |=> !send_stall);

  a_r4_setup_keeps_feature: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt && feat0_q && !(clrfeat_evt && clrfeat_ep == 3'd0) && !fw_clr[0] |=> feat0_q);

  a_r5_request_masks_ep0: assert property (@(posedge clk) disable iff (!rst_n)
    (getstat_evt && getstat_ep == 3'd0) || fwdec_evt |=> !halt_status[0]);

  a_r6_config_clears_others: assert property (@(posedge clk) disable iff (!rst_n)
    setcfg_evt && !stall_evt && !setfeat_evt |=> other_q == 8'd0);

  a_r7_config_spares_ep0: assert property (@(posedge clk) disable iff (!rst_n)
    (setcfg_evt || setif_evt) && ep0_halt && !setup_evt && !fw_clr[0]
      && !(clrfeat_evt && clrfeat_ep == 3'd0) |=> ep0_halt);

  a_r2_stall_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt && stall_ep != 3'd0 && OTHER_EPS[stall_ep] |=> other_q[$past(stall_ep)]);

endmodule

// File: tb/ep_halt_tracker_test.sv
`timescale 1ns/1ps
module ep_halt_tracker_test;
  localparam int IF_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ep_en = 8'hFF;
  logic [8*IF_W-1:0] ep_if_map;
  logic stall_evt = 0, setup_evt = 0, setfeat_evt = 0, clrfeat_evt = 0;
  logic getstat_evt = 0, fwdec_evt = 0, setif_evt = 0, setcfg_evt = 0;
  logic [2:0] stall_ep = 0, setfeat_ep = 0, clrfeat_ep = 0, getstat_ep = 0;
  logic [IF_W-1:0] setif_num = 0;
  logic [7:0] fw_clr = 0;
  logic [7:0] halt_status;
  logic send_stall;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [7:0] m_oth = 0;
  logic m_ss = 0, m_feat = 0, m_mask = 0;

  ep_halt_tracker #(.IF_W(IF_W)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL R10 watchdog: cycles=%0d expected < 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s = {m_oth[7], 2'b00, m_oth[4:1], (m_ss | m_feat) & ~m_mask};
    return s & ep_en;
  endfunction

  task automatic model_update();
    logic [7:0] setv, clrv;
    for (int n = 1; n < 8; n++) begin
      setv[n] = (stall_evt && stall_ep == n) || (setfeat_evt && setfeat_ep == n);
      clrv[n] = (clrfeat_evt && clrfeat_ep == n) || fw_clr[n] || setcfg_evt ||
                (setif_evt && ep_if_map[n*IF_W +: IF_W] == setif_num);
      if (n != 5 && n != 6) m_oth[n] = setv[n] ? 1'b1 : (clrv[n] ? 1'b0 : m_oth[n]);
    end
    if (stall_evt && stall_ep == 0) m_ss = 1; else if (setup_evt) m_ss = 0;
    if (setfeat_evt && setfeat_ep == 0) m_feat = 1;
    else if ((clrfeat_evt && clrfeat_ep == 0) || fw_clr[0]) m_feat = 0;
    if ((getstat_evt && getstat_ep == 0) || (clrfeat_evt && clrfeat_ep == 0) ||
        (setfeat_evt && setfeat_ep == 0) || fwdec_evt) m_mask = 1;
    else if (setup_evt) m_mask = 0;
  endtask

  task automatic clear_pulses();
    stall_evt = 0; setup_evt = 0; setfeat_evt = 0; clrfeat_evt = 0;
    getstat_evt = 0; fwdec_evt = 0; setif_evt = 0; setcfg_evt = 0; fw_clr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic chk(string tag, logic [7:0] es, logic ess);
    checks++;
    if (halt_status !== es || send_stall !== ess) begin
      errors++;
      $display("FAIL %s: status=%02h send_stall=%b expected status=%02h send_stall=%b",
               tag, halt_status, send_stall, es, ess);
    end
  endtask

  initial begin
    ep_if_map = '0;
    ep_if_map[1*IF_W +: IF_W] = 0; ep_if_map[2*IF_W +: IF_W] = 0;
    ep_if_map[3*IF_W +: IF_W] = 1; ep_if_map[4*IF_W +: IF_W] = 1;
    ep_if_map[7*IF_W +: IF_W] = 2; ep_if_map[5*IF_W +: IF_W] = 3;
    ep_if_map[6*IF_W +: IF_W] = 3;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", 8'h00, 0);

    stall_evt = 1; stall_ep = 0; tick(); chk("R3 stall ep0", 8'h01, 1);
    setup_evt = 1; tick(); chk("R3 setup clears", 8'h00, 0);
    stall_evt = 1; stall_ep = 5; tick(); chk("R2 ep5 ignored", 8'h00, 0);
    stall_evt = 1; stall_ep = 7; tick(); chk("R1 ep7 at bit7", 8'h80, 0);
    stall_evt = 1; stall_ep = 2; tick(); chk("R2 stall ep2", 8'h84, 0);
    setup_evt = 1; tick(); chk("R6 setup keeps", 8'h84, 0);
    setfeat_evt = 1; setfeat_ep = 3; tick(); chk("R4 setfeat ep3", 8'h8C, 0);
    setif_evt = 1; setif_num = 1; tick(); chk("R6 setif 1", 8'h84, 0);
    setif_evt = 1; setif_num = 3; tick(); chk("R6 setif nomatch", 8'h84, 0);
    setif_evt = 1; setif_num = 2; tick(); chk("R6 setif 2", 8'h04, 0);
    clrfeat_evt = 1; clrfeat_ep = 2; tick(); chk("R6 clrfeat ep2", 8'h00, 0);

    setfeat_evt = 1; setfeat_ep = 0; tick(); chk("R5 setfeat ep0 masked", 8'h00, 0);
    setup_evt = 1; tick(); chk("R4 visible after setup", 8'h01, 0);
    setup_evt = 1; tick(); chk("R4 survives setup", 8'h01, 0);
    setcfg_evt = 1; tick(); chk("R7 setcfg spares ep0", 8'h01, 0);
    setif_evt = 1; setif_num = 0; tick(); chk("R7 setif spares ep0", 8'h01, 0);
    getstat_evt = 1; getstat_ep = 0; tick(); chk("R5 getstat masks", 8'h00, 0);
    setup_evt = 1; tick(); chk("R5 unmask on setup", 8'h01, 0);
    fwdec_evt = 1; tick(); chk("R5 fw request masks", 8'h00, 0);
    setup_evt = 1; tick(); chk("R5 unmask again", 8'h01, 0);
    clrfeat_evt = 1; clrfeat_ep = 0; tick(); chk("R4 clrfeat ep0", 8'h00, 0);
    setup_evt = 1; tick(); chk("R4 cleared", 8'h00, 0);
    stall_evt = 1; stall_ep = 0; tick();
    fw_clr = 8'h01; tick(); chk("R4 fw_clr keeps protocol halt", 8'h01, 1);
    setup_evt = 1; tick(); chk("R3 protocol cleared", 8'h00, 0);

    stall_evt = 1; stall_ep = 1; ep_en = 8'hFD; tick(); chk("R8 disabled reads 0", 8'h00, 0);
    ep_en = 8'hFF; #0.1; chk("R8 re-enabled", 8'h02, 0);
    fw_clr = 8'h02; tick(); chk("R6 fw_clr ep1", 8'h00, 0);

    stall_evt = 1; stall_ep = 4; clrfeat_evt = 1; clrfeat_ep = 4; tick();
    chk("R9 set beats clrfeat", 8'h10, 0);
    setcfg_evt = 1; setfeat_evt = 1; setfeat_ep = 1; tick();
    chk("R9 set beats setcfg", 8'h02, 0);
    stall_evt = 1; stall_ep = 0; setup_evt = 1; tick();
    chk("R9 stall beats setup", 8'h03, 1);
    fw_clr = 8'hFF; setup_evt = 1; tick(); chk("R6 clear all", 8'h00, 0);

    for (int i = 0; i < 4000; i++) begin
      stall_evt   = ($urandom % 8) == 0; stall_ep   = 3'($urandom);
      setup_evt   = ($urandom % 6) == 0;
      setfeat_evt = ($urandom % 10) == 0; setfeat_ep = 3'($urandom);
      clrfeat_evt = ($urandom % 10) == 0; clrfeat_ep = 3'($urandom);
      getstat_evt = ($urandom % 12) == 0; getstat_ep = 3'($urandom);
      fwdec_evt   = ($urandom % 16) == 0;
      setif_evt   = ($urandom % 14) == 0; setif_num  = IF_W'($urandom);
      setcfg_evt  = ($urandom % 30) == 0;
      fw_clr      = (($urandom % 10) == 0) ? 8'($urandom) : 8'h00;
      if (($urandom % 50) == 0) ep_en = 8'($urandom) | 8'h60;
      if (($urandom % 40) == 0) ep_en = 8'hFF;
      tick();
      chk("R10 model", exp_status(), m_ss);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule